// File: doc/BRIEF.md
# CAN Transmit Buffer Request Scheduler

This block holds the per-buffer control state for eight message buffers of a CAN controller and chooses which buffer the protocol engine sends next. Software sets each buffer to transmit or receive. It posts or withdraws send requests and gives each buffer a two-bit priority. It does all of this through four 16-bit control words, and each word carries two buffers.

The scheduler is a three-state machine. In `ST_IDLE` it looks for a pending transmit buffer. Transition `IDLE->START` happens when at least one buffer is eligible, and the chosen index is latched on that edge. `ST_START` drives a one-cycle start pulse and always moves on to `ST_WAIT` (`START->WAIT`). `ST_WAIT` holds until the engine reports one outcome (done, aborted, lost arbitration or bus error), then returns to idle (`WAIT->IDLE`). Every return to idle is a new scheduling point.

Outcome flags are recorded per buffer. A buffer that loses arbitration or sees a bus error keeps its request and is offered again. A withdrawn request is an abort. The abort completes at once for a buffer that is not with the engine, and on engine confirmation for the buffer that is. A received remote frame can re-arm a buffer that has auto-remote enabled.

Top module: `can_txsched`

## Requirements
- R1: After reset every control bit of every buffer reads 0, `eng_start` is 0 and `eng_abort` is 0.
- R2: Control word `reg_addr = a` holds buffer 2a in bits 7:0 and buffer 2a+1 in bits 15:8. Each byte has the same layout: bit 7 transmit enable, bit 6 aborted, bit 5 lost arbitration, bit 4 bus error, bit 3 send request, bit 2 auto-remote enable, bits 1:0 priority. Bits 6:4 ignore writes. The other bits take the written value, except for the abort rules of R7 and R8.
- R3: A buffer is eligible when transmit enable = 1 and send request = 1. When a request is written at clock edge E and the machine is idle, `eng_start` is high for exactly the cycle after edge E+1, with `eng_idx` naming the buffer. Receive buffers (transmit enable = 0) are never offered.
- R4: Only one buffer is with the engine at a time. No new start is issued until the engine reports an outcome.
- R5: `eng_done` clears the send request of the active buffer and leaves its flags unchanged.
- R6: `eng_lost` sets the lost-arbitration flag and `eng_err` sets the bus-error flag. In both cases the send request stays 1 and the buffer is offered again.
- R7: Writing 0 to a send request that is 1, for a buffer that is not with the engine, clears the request and sets the aborted flag on that edge.
- R8: Writing 0 to the send request of the buffer with the engine raises `eng_abort` and keeps the request at 1. Then `eng_aborted` clears the request and sets the aborted flag. If `eng_done` arrives instead, the request clears and the aborted flag stays 0.
- R9: A 0-to-1 change of the send request clears the aborted and lost-arbitration flags. It leaves the bus-error flag unchanged.
- R10: A remote-frame pulse for a buffer with auto-remote enable = 1 sets its send request. With auto-remote enable = 0 the request is unchanged.
- R11: Among eligible buffers the highest priority wins (3 highest, 0 lowest). Equal priorities go to the higher buffer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed control word |
| reg_addr | input | 2 | Control word select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read of the addressed control word |
| rtr_valid | input | 1 | One-cycle pulse: remote frame received |
| rtr_idx | input | 3 | Buffer the remote frame matched |
| eng_start | output | 1 | One-cycle start pulse to the protocol engine |
| eng_idx | output | 3 | Buffer index being offered or sent |
| eng_abort | output | 1 | Abort requested for the active buffer |
| eng_done | input | 1 | Engine outcome: sent successfully |
| eng_aborted | input | 1 | Engine outcome: abort confirmed |
| eng_lost | input | 1 | Engine outcome: arbitration lost |
| eng_err | input | 1 | Engine outcome: bus error |

## Verification
Control bits change on the edge that samples a write, a remote pulse or an outcome. The bench therefore reads the words at the falling edge right after that edge. A start pulse follows a request two edges later: one edge stores the request, and the next moves the machine from idle to start. The bench samples at those falling edges and confirms that the pulse is gone at the following one. Outcomes are accepted only in the wait state, so each start is followed by one more falling edge before the bench drives an outcome. Each re-offer is awaited by polling a bounded number of falling edges.

// File: rtl/can_txsched_pkg.sv
package can_txsched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } sched_state_e;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PRIO_W  = 2;
    localparam int unsigned B_TXEN  = 7;
    localparam int unsigned B_ABT   = 6;
    localparam int unsigned B_LARB  = 5;
    localparam int unsigned B_BERR  = 4;
    localparam int unsigned B_REQ   = 3;
    localparam int unsigned B_ARTR  = 2;

endpackage

// File: rtl/can_txsched_buf.sv
module can_txsched_buf
    import can_txsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rtr_hit,
    input  logic              active,
    input  logic              oc_en,
    input  logic              oc_done,
    input  logic              oc_abt,
    input  logic              oc_lost,
    input  logic              oc_err,
    output logic [BYTE_W-1:0] ctrl,
    output logic              abort_pend
);
    logic              txen, abt, larb, berr, req, artr;
    logic [PRIO_W-1:0] prio;
    logic              take;

    assign take = active && oc_en && (oc_done || oc_abt || oc_lost || oc_err);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txen <= 1'b0; abt <= 1'b0; larb <= 1'b0; berr <= 1'b0;
            req <= 1'b0; artr <= 1'b0; prio <= '0; abort_pend <= 1'b0;
        end else begin
            if (wr_en) begin
                txen <= wdata[B_TXEN];
                artr <= wdata[B_ARTR];
                prio <= wdata[PRIO_W-1:0];
                if (wdata[B_REQ] && !req) begin
                    req <= 1'b1; abt <= 1'b0; larb <= 1'b0;
                end else if (!wdata[B_REQ] && req) begin
                    if (active) begin
                        abort_pend <= 1'b1;
                    end else begin
                        req <= 1'b0; abt <= 1'b1;
                    end
                end
            end
            if (rtr_hit && artr && !req) begin
                req <= 1'b1; abt <= 1'b0; larb <= 1'b0;
            end
            if (take) begin
                abort_pend <= 1'b0;
                if (oc_done) begin
                    req <= 1'b0;
                end else if (oc_abt) begin
                    req <= 1'b0; abt <= 1'b1;
                end else begin
                    if (oc_lost) larb <= 1'b1;
                    if (oc_err)  berr <= 1'b1;
                    if (abort_pend) begin
                        req <= 1'b0; abt <= 1'b1;
                    end
                end
            end
        end
    end

    assign ctrl = {txen, abt, larb, berr, req, artr, prio};

    // R5
    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (active && oc_en && oc_done) |=> !req);
    // R9
    a_r9_set_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (!abt && !larb));
    // R10
    a_r10_rtr_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rtr_hit && !artr && !wr_en && !take) |=> $stable(req));
    // R7
    a_r7_idle_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[B_REQ] && req && !active && !rtr_hit) |=> (!req && abt));
endmodule

// File: rtl/can_txsched_pick.sv
module can_txsched_pick
    import can_txsched_pkg::*;
#(
    parameter int unsigned NBUF  = 8,
    localparam int unsigned IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]             cand,
    input  logic [NBUF-1:0][PRIO_W-1:0] prio,
    output logic                        valid,
    output logic [IDX_W-1:0]            sel
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid = 1'b0;
        sel   = '0;
        best  = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (cand[i] && (!valid || prio[i] >= best)) begin
                valid = 1'b1;
                sel   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/can_txsched.sv
module can_txsched
    import can_txsched_pkg::*;
#(
    parameter int unsigned NBUF   = 8,
    localparam int unsigned IDX_W  = $clog2(NBUF),
    localparam int unsigned NREG   = NBUF / 2,
    localparam int unsigned ADDR_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              rtr_valid,
    input  logic [IDX_W-1:0]  rtr_idx,
    output logic              eng_start,
    output logic [IDX_W-1:0]  eng_idx,
    output logic              eng_abort,
    input  logic              eng_done,
    input  logic              eng_aborted,
    input  logic              eng_lost,
    input  logic              eng_err
);
    sched_state_e                 state;
    logic [IDX_W-1:0]             act_idx;
    logic [BYTE_W-1:0]            ctrl [NBUF];
    logic [NBUF-1:0]              pend;
    logic [NBUF-1:0]              cand;
    logic [NBUF-1:0][PRIO_W-1:0]  prio;
    logic                         pick_valid;
    logic [IDX_W-1:0]             pick_sel;
    logic                         outcome;
    logic                         in_wait;

    assign in_wait = (state == ST_WAIT);
    assign outcome = eng_done || eng_aborted || eng_lost || eng_err;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        can_txsched_buf u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr && (reg_addr == ADDR_W'(i / 2))),
            .wdata      (reg_wdata[(i % 2) * BYTE_W +: BYTE_W]),
            .rtr_hit    (rtr_valid && (rtr_idx == IDX_W'(i))),
            .active     ((state != ST_IDLE) && (act_idx == IDX_W'(i))),
            .oc_en      (in_wait),
            .oc_done    (eng_done),
            .oc_abt     (eng_aborted),
            .oc_lost    (eng_lost),
            .oc_err     (eng_err),
            .ctrl       (ctrl[i]),
            .abort_pend (pend[i])
        );
        assign cand[i] = ctrl[i][B_TXEN] && ctrl[i][B_REQ];
        assign prio[i] = ctrl[i][PRIO_W-1:0];
    end

    can_txsched_pick #(.NBUF(NBUF)) u_pick (
        .cand  (cand),
        .prio  (prio),
        .valid (pick_valid),
        .sel   (pick_sel)
    );

    always_comb begin
        reg_rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (reg_addr == ADDR_W'(r)) reg_rdata = {ctrl[2*r+1], ctrl[2*r]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            act_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pick_valid) begin
                    state   <= ST_START;
                    act_idx <= pick_sel;
                end
                ST_START: state <= ST_WAIT;
                ST_WAIT:  if (outcome) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_start = (state == ST_START);
        eng_idx   = act_idx;
        eng_abort = (state != ST_IDLE) && pend[act_idx];
    end

    // R4
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R4
    a_r4_hold_until_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !outcome) |=> !eng_start);
    // R8
    a_r8_abort_drops_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && eng_aborted) |=> !eng_abort);
endmodule

// File: tb/tb_can_txsched.sv
module tb_can_txsched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rtr_valid = 1'b0;
    logic [2:0]  rtr_idx = '0;
    logic        eng_start;
    logic [2:0]  eng_idx;
    logic        eng_abort;
    logic        eng_done = 1'b0, eng_aborted = 1'b0, eng_lost = 1'b0, eng_err = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    can_txsched dut (.*);

    localparam int NV = 6;
    localparam logic [15:0] VREG [NV][4] = '{
        '{16'h8B88, 16'h0089, 16'h0000, 16'h0000},
        '{16'h0088, 16'h8A00, 16'h8A00, 16'h0089},
        '{16'h0088, 16'h0000, 16'h0088, 16'h0B00},
        '{16'h8A88, 16'h8A8A, 16'h8A8A, 16'h8A8A},
        '{16'h0088, 16'h008B, 16'h0000, 16'h8A8B},
        '{16'h8888, 16'h8300, 16'h0000, 16'h0000}
    };
    localparam logic [2:0] VIDX [NV] = '{3'd1, 3'd5, 3'd4, 3'd7, 3'd6, 3'd1};
    localparam int         VCNT [NV] = '{2, 3, 1, 7, 3, 1};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_wr = 1'b0; rtr_valid = 1'b0;
        eng_done = 1'b0; eng_aborted = 1'b0; eng_lost = 1'b0; eng_err = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int kind);
        case (kind)
            0: eng_done = 1'b1;
            1: eng_aborted = 1'b1;
            2: eng_lost = 1'b1;
            default: eng_err = 1'b1;
        endcase
        @(negedge clk);
        eng_done = 1'b0; eng_aborted = 1'b0; eng_lost = 1'b0; eng_err = 1'b0;
    endtask

    task automatic rtr(input logic [2:0] i);
        rtr_valid = 1'b1; rtr_idx = i;
        @(negedge clk);
        rtr_valid = 1'b0;
    endtask

    // waits for a start, then steps into the wait state
    task automatic wait_start(output logic found, output logic [2:0] idx);
        found = 1'b0;
        idx = '0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!found && eng_start) begin
                found = 1'b1;
                idx = eng_idx;
                break;
            end
        end
        if (found) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic        f;
        logic [2:0]  ix;
        int          cnt;

        do_reset();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 word", d, 16'h0000);
        end
        chk("R1 start", {15'd0, eng_start}, 16'd0);
        chk("R1 abort", {15'd0, eng_abort}, 16'd0);

        // R2 read-only flags ignore writes, byte placement
        wr(2'd1, 16'h7777);
        rd(2'd1, d);
        chk("R2 ro bits", d, 16'h0707);
        wr(2'd3, 16'h0400);
        rd(2'd3, d);
        chk("R2 odd byte", d, 16'h0400);

        // vector table: buffer 0 blocks the engine while the rest is loaded (R11, R3)
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(2'd0, 16'h0088);
            wait_start(f, ix);
            chk("R3 blocker", {12'd0, f, ix}, {12'd0, 1'b1, 3'd0});
            for (int r = 0; r < 4; r++) wr(2'(r), VREG[v][r]);
            pulse(0);
            wait_start(f, ix);
            chk("R11 first pick", {12'd0, f, ix}, {12'd0, 1'b1, VIDX[v]});
            cnt = f ? 1 : 0;
            while (f) begin
                pulse(0);
                wait_start(f, ix);
                if (f) cnt++;
            end
            chk("R3 offer count", 16'(cnt), 16'(VCNT[v]));
        end

        // R3 start timing, R4 single pulse
        do_reset();
        wr(2'd0, 16'h0088);
        chk("R3 no early start", {15'd0, eng_start}, 16'd0);
        @(negedge clk);
        chk("R3 start", {12'd0, eng_start, eng_idx}, {12'd0, 1'b1, 3'd0});
        @(negedge clk);
        chk("R4 one cycle", {15'd0, eng_start}, 16'd0);

        // R4 no preemption while busy
        wr(2'd3, 16'h8B00);
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (eng_start) cnt++;
        end
        chk("R4 busy", 16'(cnt), 16'd0);
        pulse(0);
        wait_start(f, ix);
        chk("R4 next", {12'd0, f, ix}, {12'd0, 1'b1, 3'd7});

        // R5 done clears request only
        pulse(0);
        rd(2'd0, d);
        chk("R5 buf0", d, 16'h0080);
        rd(2'd3, d);
        chk("R5 buf7", d, 16'h8300);

        // R6 lost arbitration and bus error keep the request
        do_reset();
        wr(2'd0, 16'h0088);
        wait_start(f, ix);
        pulse(2);
        rd(2'd0, d);
        chk("R6 lost", d, 16'h00A8);
        wait_start(f, ix);
        chk("R6 reoffer", {12'd0, f, ix}, {12'd0, 1'b1, 3'd0});
        pulse(3);
        rd(2'd0, d);
        chk("R6 err", d, 16'h00B8);
        wait_start(f, ix);
        pulse(0);
        rd(2'd0, d);
        chk("R6 done keeps flags", d, 16'h00B0);

        // R9 new request clears aborted and lost, keeps error
        wr(2'd0, 16'h0088);
        rd(2'd0, d);
        chk("R9 clear", d, 16'h0098);
        wait_start(f, ix);
        pulse(0);

        // R7 abort of a buffer not with the engine
        wr(2'd1, 16'h0008);
        rd(2'd1, d);
        chk("R7 pending", d, 16'h0008);
        wr(2'd1, 16'h0000);
        rd(2'd1, d);
        chk("R7 aborted", d, 16'h0040);

        // R8 abort of the active buffer
        do_reset();
        wr(2'd0, 16'h0088);
        wait_start(f, ix);
        wr(2'd0, 16'h0080);
        chk("R8 abort out", {15'd0, eng_abort}, 16'd1);
        rd(2'd0, d);
        chk("R8 req held", d, 16'h0088);
        pulse(1);
        rd(2'd0, d);
        chk("R8 confirmed", d, 16'h00C0);
        chk("R8 abort drop", {15'd0, eng_abort}, 16'd0);
        wr(2'd0, 16'h0088);
        wait_start(f, ix);
        wr(2'd0, 16'h0080);
        pulse(0);
        rd(2'd0, d);
        chk("R8 done wins", d, 16'h0080);

        // R10 remote frame re-arms
        do_reset();
        wr(2'd0, 16'h0004);
        rtr(3'd0);
        rd(2'd0, d);
        chk("R10 armed", d, 16'h000C);
        rtr(3'd1);
        rd(2'd0, d);
        chk("R10 disabled", d, 16'h000C);
        wr(2'd1, 16'h0084);
        rtr(3'd2);
        wait_start(f, ix);
        chk("R10 tx start", {12'd0, f, ix}, {12'd0, 1'b1, 3'd2});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule